// File: doc/BRIEF.md
# Dual-Rate Weight-Cached Multiply-Accumulate Element

This processing element sits inside a convolution array. It takes two 16-bit
signed activation streams, one per fabric cycle each, multiplies each by a
cached weight and adds both products to an incoming 40-bit partial sum. The
sum leaves as a cascade output for the next element in the column. Both
activations are also handed on, one fabric cycle later, to the neighbouring
element in the row.

One multiplier and one adder serve both streams. They run on a fast clock
that is exactly twice the fabric clock and rising-edge aligned with it. In the
first fast cycle of each fabric cycle the core forms stream A's product plus
the cascade input. In the second it adds stream B's product. A toggle register
in the fabric domain, compared against a copy taken in the fast domain, tells
the core which half of the fabric cycle it is in. The captured activations act
as the two alternating operand buffers on the product side.

The weight cache has two banks of two entries each: entry 0 serves stream A and
entry 1 serves stream B. One bank feeds the core while the other is refilled
through the update port. A write aimed at the bank in use is dropped. A swap
strobe, issued at tile boundaries, exchanges the roles of the two banks.

Top module: `mac_pe_dualrate`

## Requirements
- R1: While reset is low at a fabric clock edge, all outputs go to zero, both weight banks clear to zero and bank 0 becomes active. After release, `psum_out` stays zero until the first sampled inputs have passed through.
- R2: Inputs sampled at fabric edge n appear on `psum_out` after edge n+2 as `psum_in + act_a*W0 + act_b*W1`. W0 and W1 are entries 0 and 1 of the bank active at edge n. A new result is produced every fabric cycle.
- R3: `act_a_fwd` and `act_b_fwd` show the values of `act_a` and `act_b` that were sampled at the previous fabric edge.
- R4: With `upd_we` high at an edge, `upd_bank` (0 or 1) names the bank and `upd_idx` names the entry (0 for stream A, 1 for stream B). If that bank is not active, `upd_data` is stored there. The stored weight is used by samples from the next edge onward once that bank is active.
- R5: A write whose `upd_bank` equals the active bank is ignored. The contents of that bank do not change.
- R6: `bank_swap` high at edge n makes the other bank active from edge n+1. Inputs sampled at edge n still use the old bank. A write at edge n is judged against the old active bank.
- R7: Activations and weights are two's complement. Each 32-bit product is sign-extended to 40 bits, and the sum wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Fabric clock |
| clk_fast | input | 1 | Core clock, twice `clk_slow`, rising edges aligned |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| act_a | input | 16 | Stream A activation, signed |
| act_b | input | 16 | Stream B activation, signed |
| psum_in | input | 40 | Cascade partial sum from the previous element |
| upd_we | input | 1 | Weight write enable |
| upd_bank | input | 1 | Target bank of the weight write |
| upd_idx | input | 1 | Target entry: 0 for stream A, 1 for stream B |
| upd_data | input | 16 | Weight value, signed |
| bank_swap | input | 1 | Exchange the active and refill banks |
| act_a_fwd | output | 16 | Stream A activation passed on, delayed one fabric cycle |
| act_b_fwd | output | 16 | Stream B activation passed on, delayed one fabric cycle |
| psum_out | output | 40 | Cascade partial sum out, registered on the fabric clock |

## Verification
The bench aims at the edge where a swap and a write land together. A design
that judged the write against the new bank would corrupt the weights that
become active again after the next swap. It also writes to the bank in use,
which a leaky design would show at once as a changed sum. Extreme operands
(-32768 squared, and a cascade input near 2^40) expose a missing sign extension
or a carry handled the wrong way. Long random streams with scattered swaps show
any phase mix-up between the two fast cycles as a product attached to the wrong
weight or to the wrong fabric cycle. A reset in the middle of a run checks that
the fast-domain state and the cache both clear.

// File: rtl/mac_pe_pkg.sv
// Shared constants and types for the dual-rate MAC element.
// Assumes a fixed 2:1 clock ratio, hence two lanes per fabric cycle.
package mac_pe_pkg;
    localparam int PE_DATA_W = 16;
    localparam int PE_ACC_W  = 40;
    localparam int PE_LANES  = 2;
    localparam int PE_IDX_W  = $clog2(PE_LANES);
    localparam int PE_BANKS  = 2;

    // Which half of a fabric cycle the fast core is working on.
    typedef enum logic {
        PH_HEAD = 1'b0,
        PH_TAIL = 1'b1
    } pe_phase_e;
endpackage

// File: rtl/mac_pe_wcache.sv
// Two-bank weight cache. One bank is active and drives the lanes; the
// other accepts writes. Writes aimed at the active bank are dropped.
// A swap strobe flips the active bank at the next fabric edge.
// Assumes all inputs are synchronous to clk.
module mac_pe_wcache
    import mac_pe_pkg::*;
#(
    parameter int DATA_W = PE_DATA_W,
    parameter int LANES  = PE_LANES,
    parameter int IDX_W  = PE_IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd_we,
    input  logic                         upd_bank,
    input  logic [IDX_W-1:0]             upd_idx,
    input  logic [DATA_W-1:0]            upd_data,
    input  logic                         bank_swap,
    output logic [LANES-1:0][DATA_W-1:0] lane_w,
    output logic                         active_bank
);
    logic active_q;

    // Active-bank pointer: flips on a swap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         active_q <= 1'b0;
        else if (bank_swap) active_q <= ~active_q;
    end

    for (genvar b = 0; b < PE_BANKS; b++) begin : g_bank
        logic [LANES-1:0][DATA_W-1:0] mem;
        // Bank storage: accepts a write only while this bank is idle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem <= '0;
            else if (upd_we && (upd_bank == 1'(b)) && (active_q != 1'(b)))
                mem[upd_idx] <= upd_data;
        end
    end

    assign lane_w      = active_q ? g_bank[1].mem : g_bank[0].mem;
    assign active_bank = active_q;
endmodule

// File: rtl/mac_pe_fastcore.sv
// Time-multiplexed multiply-add on the 2x clock. The head cycle forms
// psum + a*w0 into an accumulator. The tail cycle adds b*w1 and latches
// the result for the fabric domain. The phase comes from comparing the
// fabric toggle with its fast-domain copy.
// Assumes clk_fast is exactly 2x clk_slow with rising edges aligned, and
// ACC_W > 2*DATA_W. The operands are fabric registers held across both
// fast cycles.
module mac_pe_fastcore
    import mac_pe_pkg::*;
#(
    parameter int DATA_W = PE_DATA_W,
    parameter int ACC_W  = PE_ACC_W
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              tgl_slow,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] w_a,
    input  logic [DATA_W-1:0] w_b,
    input  logic [ACC_W-1:0]  psum,
    output logic [ACC_W-1:0]  result,
    output pe_phase_e         phase
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic                     tgl_seen;
    logic [ACC_W-1:0]         acc_q;
    logic [ACC_W-1:0]         res_q;
    logic [DATA_W-1:0]        mux_act;
    logic [DATA_W-1:0]        mux_w;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         prod_ext;
    logic [ACC_W-1:0]         addend;
    logic [ACC_W-1:0]         sum;

    // Phase tracker: copies the fabric toggle on every fast edge.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) tgl_seen <= 1'b0;
        else        tgl_seen <= tgl_slow;
    end

    assign phase = (tgl_slow != tgl_seen) ? PH_HEAD : PH_TAIL;

    // Shared datapath: the operand pair is picked by the phase.
    always_comb begin
        mux_act  = (phase == PH_HEAD) ? op_a : op_b;
        mux_w    = (phase == PH_HEAD) ? w_a  : w_b;
        prod     = $signed(mux_act) * $signed(mux_w);
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        addend   = (phase == PH_HEAD) ? psum : acc_q;
        sum      = addend + prod_ext;
    end

    // Head cycle fills the accumulator; tail cycle posts the result.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else if (phase == PH_HEAD) begin
            acc_q <= sum;
        end else begin
            res_q <= sum;
        end
    end

    assign result = res_q;
endmodule

// File: rtl/mac_pe_dualrate.sv
// Dual-rate weight-cached MAC element. The fabric domain captures the
// operands, weights and cascade input, forwards the activations and
// registers the cascade output. The fast core does two multiply-adds per
// fabric cycle. Latency from input sample to psum_out is two fabric edges.
// Assumes clk_fast = 2x clk_slow, rising-edge aligned, with one shared
// synchronous reset.
module mac_pe_dualrate
    import mac_pe_pkg::*;
#(
    parameter int DATA_W = PE_DATA_W,
    parameter int ACC_W  = PE_ACC_W
) (
    input  logic                clk_slow,
    input  logic                clk_fast,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   act_a,
    input  logic [DATA_W-1:0]   act_b,
    input  logic [ACC_W-1:0]    psum_in,
    input  logic                upd_we,
    input  logic                upd_bank,
    input  logic [PE_IDX_W-1:0] upd_idx,
    input  logic [DATA_W-1:0]   upd_data,
    input  logic                bank_swap,
    output logic [DATA_W-1:0]   act_a_fwd,
    output logic [DATA_W-1:0]   act_b_fwd,
    output logic [ACC_W-1:0]    psum_out
);
    logic [PE_LANES-1:0][DATA_W-1:0] lane_w;
    logic                            active_bank;
    logic [DATA_W-1:0]               cap_a, cap_b, cap_wa, cap_wb;
    logic [ACC_W-1:0]                cap_psum;
    logic                            tgl_q;
    logic [ACC_W-1:0]                core_res;
    pe_phase_e                       core_phase;

    mac_pe_wcache #(.DATA_W(DATA_W), .LANES(PE_LANES), .IDX_W(PE_IDX_W)) u_wcache (
        .clk        (clk_slow),
        .rst_n      (rst_n),
        .upd_we     (upd_we),
        .upd_bank   (upd_bank),
        .upd_idx    (upd_idx),
        .upd_data   (upd_data),
        .bank_swap  (bank_swap),
        .lane_w     (lane_w),
        .active_bank(active_bank)
    );

    // Operand capture: holds one fabric cycle of work for the fast core.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_b    <= '0;
            cap_wa   <= '0;
            cap_wb   <= '0;
            cap_psum <= '0;
            tgl_q    <= 1'b0;
        end else begin
            cap_a    <= act_a;
            cap_b    <= act_b;
            cap_wa   <= lane_w[0];
            cap_wb   <= lane_w[1];
            cap_psum <= psum_in;
            tgl_q    <= ~tgl_q;
        end
    end

    mac_pe_fastcore #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_core (
        .clk_fast(clk_fast),
        .rst_n   (rst_n),
        .tgl_slow(tgl_q),
        .op_a    (cap_a),
        .op_b    (cap_b),
        .w_a     (cap_wa),
        .w_b     (cap_wb),
        .psum    (cap_psum),
        .result  (core_res),
        .phase   (core_phase)
    );

    // Output stage: forwards activations and registers the cascade sum.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            act_a_fwd <= '0;
            act_b_fwd <= '0;
            psum_out  <= '0;
        end else begin
            act_a_fwd <= act_a;
            act_b_fwd <= act_b;
            psum_out  <= core_res;
        end
    end
endmodule

// File: rtl/mac_pe_dualrate_chk.sv
// Property checker for mac_pe_dualrate, attached by bind below.
module mac_pe_dualrate_chk
    import mac_pe_pkg::*;
#(
    parameter int DATA_W = PE_DATA_W,
    parameter int ACC_W  = PE_ACC_W
) (
    input logic                            clk_slow,
    input logic                            clk_fast,
    input logic                            rst_n,
    input logic [DATA_W-1:0]               act_a,
    input logic [DATA_W-1:0]               act_b,
    input logic [ACC_W-1:0]                psum_in,
    input logic                            bank_swap,
    input logic [DATA_W-1:0]               act_a_fwd,
    input logic [DATA_W-1:0]               act_b_fwd,
    input logic [ACC_W-1:0]                psum_out,
    input logic                            active_bank,
    input logic [PE_LANES-1:0][DATA_W-1:0] lane_w,
    input pe_phase_e                       core_phase
);
    // R2: a head cycle is always followed by a tail cycle.
    a_r2_head_then_tail: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (core_phase == PH_HEAD) |=> (core_phase == PH_TAIL));

    // R2: each fabric edge coincides with the tail-cycle fast edge.
    a_r2_slow_edge_tail: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $past(rst_n) |-> (core_phase == PH_TAIL));

    // R2: with both activations zero, the cascade passes through unchanged.
    a_r2_zero_acts: assert property (@(posedge clk_slow) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) &&
         ($past(act_a, 3) == '0) && ($past(act_b, 3) == '0))
        |-> (psum_out == $past(psum_in, 3)));

    // R3: forwarded activations lag the inputs by one fabric cycle.
    a_r3_forward: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $past(rst_n) |-> ((act_a_fwd == $past(act_a)) && (act_b_fwd == $past(act_b))));

    // R5: without a swap, the weights in use cannot change.
    a_r5_active_stable: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !bank_swap |=> $stable(lane_w));

    // R6: a swap strobe flips the active bank.
    a_r6_swap_toggle: assert property (@(posedge clk_slow) disable iff (!rst_n)
        bank_swap |=> (active_bank != $past(active_bank)));

    // R6: without a swap strobe, the active bank holds.
    a_r6_no_swap_hold: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !bank_swap |=> $stable(active_bank));
endmodule

bind mac_pe_dualrate mac_pe_dualrate_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk_slow   (clk_slow),
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .act_a      (act_a),
    .act_b      (act_b),
    .psum_in    (psum_in),
    .bank_swap  (bank_swap),
    .act_a_fwd  (act_a_fwd),
    .act_b_fwd  (act_b_fwd),
    .psum_out   (psum_out),
    .active_bank(active_bank),
    .lane_w     (lane_w),
    .core_phase (core_phase)
);

// File: tb/test_mac_pe_dualrate.sv
`timescale 1ns/1ps
// Bench for mac_pe_dualrate with a behavioural reference model that is
// compared on every fabric clock.
module test_mac_pe_dualrate;
    logic        clk_s = 1'b0;
    logic        clk_f = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] act_a = '0, act_b = '0, upd_data = '0;
    logic [39:0] psum_in = '0;
    logic        upd_we = 1'b0, upd_bank = 1'b0, upd_idx = 1'b0, bank_swap = 1'b0;
    logic [15:0] act_a_fwd, act_b_fwd;
    logic [39:0] psum_out;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // 125 MHz fabric clock and 250 MHz core clock, both driven from one process.
    always begin
        #2 clk_f = 1'b1; clk_s = ~clk_s;
        #2 clk_f = 1'b0;
    end

    mac_pe_dualrate i_mac_pe_dualrate (
        .clk_slow(clk_s), .clk_fast(clk_f), .rst_n(rst_n),
        .act_a(act_a), .act_b(act_b), .psum_in(psum_in),
        .upd_we(upd_we), .upd_bank(upd_bank), .upd_idx(upd_idx),
        .upd_data(upd_data), .bank_swap(bank_swap),
        .act_a_fwd(act_a_fwd), .act_b_fwd(act_b_fwd), .psum_out(psum_out)
    );

    // Reference model state.
    logic [15:0] m_w [2][2];
    bit          m_act, m_valid, m_rst;
    logic [39:0] m_p0, m_p1, m_out;
    logic [15:0] m_fa, m_fb;

    function automatic logic [39:0] ref_mac(logic [39:0] p, logic [15:0] a, logic [15:0] b,
                                            logic [15:0] wa, logic [15:0] wb);
        longint s;
        s = longint'(p) + longint'($signed(a)) * longint'($signed(wa))
                        + longint'($signed(b)) * longint'($signed(wb));
        return s[39:0];
    endfunction

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Model update at each fabric edge, from the inputs sampled there.
    always @(posedge clk_s) begin
        m_valid = 1'b1;
        if (!rst_n) begin
            m_rst = 1'b1;
            m_act = 1'b0;
            m_p0 = '0; m_p1 = '0; m_out = '0; m_fa = '0; m_fb = '0;
            for (int b = 0; b < 2; b++) for (int i = 0; i < 2; i++) m_w[b][i] = '0;
        end else begin
            m_rst = 1'b0;
            m_out = m_p1;
            m_p1  = m_p0;
            m_p0  = ref_mac(psum_in, act_a, act_b, m_w[m_act][0], m_w[m_act][1]);
            m_fa  = act_a;
            m_fb  = act_b;
            if (upd_we && (upd_bank != m_act)) m_w[upd_bank][upd_idx] = upd_data;
            if (bank_swap) m_act = ~m_act;
        end
    end

    // Compare the outputs in the middle of each fabric cycle.
    always @(negedge clk_s) begin
        if (m_valid) begin
            if (m_rst) begin
                chk("R1", "psum_out in reset", 64'(psum_out), 64'd0);
                chk("R1", "act_a_fwd in reset", 64'(act_a_fwd), 64'd0);
                chk("R1", "act_b_fwd in reset", 64'(act_b_fwd), 64'd0);
            end else begin
                chk(cur_req, "psum_out", 64'(psum_out), 64'(m_out));
                chk("R3", "act_a_fwd", 64'(act_a_fwd), 64'(m_fa));
                chk("R3", "act_b_fwd", 64'(act_b_fwd), 64'(m_fb));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk_s) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Drive one fabric cycle of inputs, then move past the next edge.
    task automatic step(logic [15:0] a, logic [15:0] b, logic [39:0] p,
                        logic we = 1'b0, logic bk = 1'b0, logic ix = 1'b0,
                        logic [15:0] d = '0, logic sw = 1'b0);
        act_a = a; act_b = b; psum_in = p;
        upd_we = we; upd_bank = bk; upd_idx = ix; upd_data = d; bank_swap = sw;
        @(posedge clk_s); #1;
    endtask

    task automatic rnd_step();
        step(16'($urandom), 16'($urandom), {8'($urandom), 32'($urandom)});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step('0, '0, '0);
    endtask

    initial begin
        repeat (4) @(posedge clk_s);
        #1 rst_n = 1'b1;

        // R1: weights are clear after reset, so the cascade passes through.
        cur_req = "R1";
        for (int i = 0; i < 5; i++) rnd_step();

        // R4: fill the idle bank 1, then swap it in.
        cur_req = "R4";
        step(16'd5, 16'd7, 40'd100, 1'b1, 1'b1, 1'b0, 16'd3);
        step(16'd5, 16'd7, 40'd100, 1'b1, 1'b1, 1'b1, 16'hFFFE);
        cur_req = "R6";
        step(16'd11, 16'd13, 40'd1000, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        cur_req = "R4";
        step(16'd11, 16'd13, 40'd1000);
        for (int i = 0; i < 4; i++) rnd_step();

        // R5: writes to the active bank 1 leave it unchanged; bank 0 takes writes.
        cur_req = "R5";
        step(16'd2, 16'd2, 40'd0, 1'b1, 1'b1, 1'b0, 16'h1234);
        step(16'd2, 16'd2, 40'd0, 1'b1, 1'b1, 1'b1, 16'h4321);
        step(16'd1, 16'd1, 40'd0);
        for (int i = 0; i < 3; i++) rnd_step();
        cur_req = "R4";
        step(16'd1, 16'd1, 40'd0, 1'b1, 1'b0, 1'b0, 16'd7);
        step(16'd1, 16'd1, 40'd0, 1'b1, 1'b0, 1'b1, 16'd9);

        // R6: swap and a write to the old active bank on the same edge.
        cur_req = "R6";
        step(16'd4, 16'd4, 40'd50, 1'b1, 1'b1, 1'b0, 16'h5555, 1'b1);
        for (int i = 0; i < 3; i++) step(16'd3, 16'd3, 40'd10);
        step(16'd6, 16'd6, 40'd20, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        for (int i = 0; i < 4; i++) step(16'd1, 16'd0, 40'd0);

        // R7: extreme operands and a wrapping cascade sum.
        cur_req = "R7";
        step(16'd0, 16'd0, 40'd0, 1'b1, 1'b0, 1'b0, 16'h8000);
        step(16'd0, 16'd0, 40'd0, 1'b1, 1'b0, 1'b1, 16'h7FFF);
        step(16'd0, 16'd0, 40'd0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        step(16'h8000, 16'h8000, 40'hFF_FFFF_FFFF);
        step(16'h7FFF, 16'h8000, 40'h00_0000_0000);
        step(16'h8000, 16'h7FFF, 40'h80_0000_0000);
        step(16'hFFFF, 16'h0001, 40'h00_0000_0001);
        idle(3);

        // R2: long random stream with scattered writes and swaps.
        cur_req = "R2";
        for (int i = 0; i < 300; i++) begin
            if (i % 16 == 5)
                step(16'($urandom), 16'($urandom), {8'($urandom), 32'($urandom)},
                     1'b1, 1'($urandom), 1'($urandom), 16'($urandom));
            else if (i % 37 == 20)
                step(16'($urandom), 16'($urandom), {8'($urandom), 32'($urandom)},
                     1'b0, 1'b0, 1'b0, '0, 1'b1);
            else
                rnd_step();
        end
        idle(3);

        // R1: reset in the middle of a run clears the cache and the pipeline.
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) rnd_step();
        rst_n = 1'b1;
        cur_req = "R1";
        for (int i = 0; i < 6; i++) rnd_step();
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule